// File: doc/BRIEF.md
# UART Modem Control and Status Unit

This block holds the modem control register of a 16550-style serial port and produces its modem status register. The control register drives the request-to-send and data-terminal-ready outputs and two general-purpose output bits. The four incoming modem lines (clear-to-send, data-set-ready, ring indicator, carrier detect) are synchronized, kept as current state, and compared with their previous value every cycle. A change on a line latches a sticky change flag. For the ring indicator the flag is latched only on a falling edge.

Reading the status register returns the current line state together with the change flags, then clears the flags. The modem-status interrupt request is active while any flag is set. A loopback test mode takes the line state from the control register instead of the pins and parks both modem outputs inactive. The surrounding register file decodes addresses and calls this block through a write strobe for the control register and a read strobe for the status register.

Top module: `modem_ctl_status`

## Requirements
- R1: After reset the control readback is 0x08 (OUT2 only), the status readback is 0xB0 (carrier, data-set-ready and clear-to-send active, ring inactive, no flags), the interrupt request is low, and both modem outputs are low.
- R2: Status bits 7, 6, 5 and 4 report carrier detect, ring indicator, data-set-ready and clear-to-send. A pin change appears there on the third rising clock edge after the change: two synchronizer stages plus the state register.
- R3: Status bits 3, 1 and 0 are the change flags for carrier detect, data-set-ready and clear-to-send. Each is set by a rising or a falling edge of its line and stays set until the status register is read.
- R4: Status bit 2 is set only when the ring indicator goes from 1 to 0. A 0-to-1 ring transition sets no flag.
- R5: A status read returns the value present during the read cycle. All four flags are clear from the following cycle, unless R6 applies.
- R6: A line change that is registered in the same cycle as a status read sets its flag. The flag is not lost to the clear.
- R7: The interrupt request is high exactly while at least one of the status bits 3..0 is set.
- R8: A control write stores data bits 4..0 (bit0 DTR, bit1 RTS, bit2 OUT1, bit3 OUT2, bit4 LOOP). Readback bits 7..5 are always 0. Outside loopback, the request-to-send output follows bit1 and the data-terminal-ready output follows bit0, one cycle after the write.
- R9: With LOOP set, the line state is taken from the control register on the second edge after the write: RTS gives clear-to-send, DTR gives data-set-ready, OUT1 gives ring, OUT2 gives carrier. The external status pins have no effect in this mode.
- R10: With LOOP set, the request-to-send and data-terminal-ready outputs are held low whatever bits 1 and 0 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mcr_wr | input | 1 | Write strobe for the control register |
| mcr_wdata | input | 8 | Write data for the control register |
| msr_rd | input | 1 | Read strobe for the status register (clears flags) |
| cts_in | input | 1 | Clear-to-send pin, active high |
| dsr_in | input | 1 | Data-set-ready pin, active high |
| ri_in | input | 1 | Ring indicator pin, active high |
| dcd_in | input | 1 | Carrier detect pin, active high |
| rts_out | output | 1 | Request-to-send output, active high |
| dtr_out | output | 1 | Data-terminal-ready output, active high |
| mcr_rdata | output | 8 | Control register readback |
| msr_rdata | output | 8 | Status register read value |
| msi_req | output | 1 | Modem-status interrupt request |

## Verification
The hardest situation to reach is a line change that lands in the same cycle as a status read. Here the clear and the set race for the same flag register. The stimulus first leaves an older flag pending, then changes a second pin and times the read strobe to the third edge after the pin change, where the synchronized change is registered. The expected result is the older flag cleared and the new one kept. Entering and leaving loopback is also driven, with the pins set against the control bits, so that both the line-source switch and the ignored pins show up in the flags.

// File: rtl/modem_pkg.sv
package modem_pkg;

    // Line state, packed in status-register order (bit 3 = MSR bit 7).
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mlines_t;

    localparam int REG_W    = 8;
    localparam int MCR_W    = 5;
    localparam int LINE_W   = 4;

    localparam int MCR_DTR  = 0;
    localparam int MCR_RTS  = 1;
    localparam int MCR_OUT1 = 2;
    localparam int MCR_OUT2 = 3;
    localparam int MCR_LOOP = 4;

    localparam logic [MCR_W-1:0] MCR_RESET = 5'b01000;
    localparam mlines_t LINES_RESET = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};

    // Loopback routing of control bits onto the status lines.
    function automatic mlines_t loop_map(input logic [MCR_W-1:0] m);
        mlines_t l;
        l.dcd = m[MCR_OUT2];
        l.ri  = m[MCR_OUT1];
        l.dsr = m[MCR_DTR];
        l.cts = m[MCR_RTS];
        return l;
    endfunction

    // Change flags: bit3 carrier, bit2 ring trailing edge, bit1 dsr, bit0 cts.
    function automatic logic [LINE_W-1:0] change_of(input mlines_t prev, input mlines_t now);
        return {prev.dcd ^ now.dcd, prev.ri & ~now.ri, prev.dsr ^ now.dsr, prev.cts ^ now.cts};
    endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int STAGES = 2,
    parameter int W      = 4,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RESET_VAL;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign dout = chain[LAST];
endmodule

// File: rtl/mcr_reg.sv
module mcr_reg
    import modem_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [REG_W-1:0]     wdata,
    output logic [MCR_W-1:0]     mcr,
    output logic                 rts,
    output logic                 dtr
);
    always_ff @(posedge clk) begin
        if (rst)     mcr <= MCR_RESET;
        else if (wr) mcr <= wdata[MCR_W-1:0];
    end

    // Outputs parked inactive while looping back.
    assign rts = mcr[MCR_RTS] & ~mcr[MCR_LOOP];
    assign dtr = mcr[MCR_DTR] & ~mcr[MCR_LOOP];
endmodule

// File: rtl/msr_track.sv
module msr_track
    import modem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mlines_t           src,
    input  logic              rd_clr,
    output mlines_t           lines_q,
    output logic [LINE_W-1:0] flags_q
);
    logic [LINE_W-1:0] kept;

    // A read clears old flags; a change seen in the same cycle still sets.
    assign kept = rd_clr ? '0 : flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lines_q <= LINES_RESET;
            flags_q <= '0;
        end else begin
            lines_q <= src;
            flags_q <= kept | change_of(lines_q, src);
        end
    end
endmodule

// File: rtl/modem_ctl_status.sv
module modem_ctl_status
    import modem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mcr_wr,
    input  logic [7:0]       mcr_wdata,
    input  logic             msr_rd,
    input  logic             cts_in,
    input  logic             dsr_in,
    input  logic             ri_in,
    input  logic             dcd_in,
    output logic             rts_out,
    output logic             dtr_out,
    output logic [7:0]       mcr_rdata,
    output logic [7:0]       msr_rdata,
    output logic             msi_req
);
    localparam int PAD_W = REG_W - MCR_W;

    logic [MCR_W-1:0]  mcr;
    logic [LINE_W-1:0] pins_raw;
    logic [LINE_W-1:0] pins_sync;
    mlines_t           src;
    mlines_t           lines_q;
    logic [LINE_W-1:0] flags_q;

    assign pins_raw = {dcd_in, ri_in, dsr_in, cts_in};

    mcr_reg u_mcr (
        .clk   (clk),
        .rst   (rst),
        .wr    (mcr_wr),
        .wdata (mcr_wdata),
        .mcr   (mcr),
        .rts   (rts_out),
        .dtr   (dtr_out)
    );

    line_sync #(
        .STAGES    (SYNC_STAGES),
        .W         (LINE_W),
        .RESET_VAL (LINES_RESET)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pins_raw),
        .dout (pins_sync)
    );

    generate
        if (SYNC_STAGES > 0) begin : g_src
            assign src = mcr[MCR_LOOP] ? loop_map(mcr) : mlines_t'(pins_sync);
        end
    endgenerate

    msr_track u_track (
        .clk     (clk),
        .rst     (rst),
        .src     (src),
        .rd_clr  (msr_rd),
        .lines_q (lines_q),
        .flags_q (flags_q)
    );

    assign mcr_rdata = {{PAD_W{1'b0}}, mcr};
    assign msr_rdata = {lines_q, flags_q};
    assign msi_req   = |flags_q;
endmodule

// File: rtl/modem_ctl_status_chk.sv
module modem_ctl_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       msr_rd,
    input logic [7:0] msr_rdata,
    input logic [7:0] mcr_rdata,
    input logic       msi_req,
    input logic       rts_out,
    input logic       dtr_out
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (msr_rdata == 8'hB0 && mcr_rdata == 8'h08 && !msi_req));

    // R3
    flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !msr_rd |=> ((msr_rdata[3:0] & $past(msr_rdata[3:0])) == $past(msr_rdata[3:0])));

    // R3
    cts_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (msr_rdata[4] != $past(msr_rdata[4])) |-> msr_rdata[0]);

    // R4
    ring_trailing_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(msr_rdata[2]) |-> $fell(msr_rdata[6]));

    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        msr_rd |=> (msr_rdata[3:0] == 4'h0 || msr_rdata[7:4] != $past(msr_rdata[7:4])));

    // R7
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(msi_req) |-> $past(msr_rd));

    // R10
    loop_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        mcr_rdata[4] |-> (!rts_out && !dtr_out));

    // R8
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        mcr_rdata[7:5] == 3'b000);
endmodule

bind modem_ctl_status modem_ctl_status_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .msr_rd    (msr_rd),
    .msr_rdata (msr_rdata),
    .mcr_rdata (mcr_rdata),
    .msi_req   (msi_req),
    .rts_out   (rts_out),
    .dtr_out   (dtr_out)
);

// File: tb/modem_ctl_status_tb.sv
module modem_ctl_status_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mcr_wr = 1'b0;
    logic [7:0] mcr_wdata = 8'h00;
    logic       msr_rd = 1'b0;
    logic       cts_in = 1'b1, dsr_in = 1'b1, ri_in = 1'b0, dcd_in = 1'b1;
    logic       rts_out, dtr_out, msi_req;
    logic [7:0] mcr_rdata, msr_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef enum logic [1:0] {K_MSR, K_MCR, K_IRQ, K_PINS} kind_t;
    typedef struct {
        kind_t      kind;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    modem_ctl_status u_dut (
        .clk(clk), .rst(rst), .mcr_wr(mcr_wr), .mcr_wdata(mcr_wdata), .msr_rd(msr_rd),
        .cts_in(cts_in), .dsr_in(dsr_in), .ri_in(ri_in), .dcd_in(dcd_in),
        .rts_out(rts_out), .dtr_out(dtr_out), .mcr_rdata(mcr_rdata),
        .msr_rdata(msr_rdata), .msi_req(msi_req)
    );

    // Monitor: compares queued expectations at the falling edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            case (it.kind)
                K_MSR:   act = msr_rdata;
                K_MCR:   act = mcr_rdata;
                K_IRQ:   act = {7'd0, msi_req};
                default: act = {6'd0, rts_out, dtr_out};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic expect_v(kind_t k, logic [7:0] v, string tag);
        item_t it;
        it.kind = k; it.exp = v; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic write_mcr(logic [7:0] v);
        mcr_wr = 1'b1; mcr_wdata = v;
        tick(1);
        mcr_wr = 1'b0;
    endtask

    // Read: value during the read, then cleared value after.
    task automatic read_msr(logic [7:0] during, logic [7:0] after, string tag);
        msr_rd = 1'b1;
        expect_v(K_MSR, during, tag);
        tick(1);
        msr_rd = 1'b0;
        expect_v(K_MSR, after, tag);
        expect_v(K_IRQ, {7'd0, |after[3:0]}, "R7 irq after read");
        tick(1);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        expect_v(K_MSR, 8'hB0, "R1 msr reset");
        expect_v(K_MCR, 8'h08, "R1 mcr reset");
        expect_v(K_IRQ, 8'h00, "R1 irq reset");
        expect_v(K_PINS, 8'h00, "R1 outputs reset");
        tick(1);

        // R2/R3: cts falls; latency of three edges
        cts_in = 1'b0;
        tick(2);
        expect_v(K_MSR, 8'hB0, "R2 not yet visible after two edges");
        tick(1);
        expect_v(K_MSR, 8'hA1, "R3 cts falling flag");
        expect_v(K_IRQ, 8'h01, "R7 irq with flag");
        tick(3);
        expect_v(K_MSR, 8'hA1, "R3 flag sticky");
        read_msr(8'hA1, 8'hA0, "R5 read clears cts flag");

        // R4: ring rise gives no flag, fall gives trailing flag
        ri_in = 1'b1;
        tick(4);
        expect_v(K_MSR, 8'hE0, "R4 ring rise no flag");
        expect_v(K_IRQ, 8'h00, "R4 irq stays low");
        ri_in = 1'b0;
        tick(3);
        expect_v(K_MSR, 8'hA4, "R4 ring trailing edge");
        read_msr(8'hA4, 8'hA0, "R5 read clears ring flag");

        // R3: dsr and carrier fall together
        dsr_in = 1'b0; dcd_in = 1'b0;
        tick(3);
        expect_v(K_MSR, 8'h0A, "R3 dsr and dcd flags");
        read_msr(8'h0A, 8'h00, "R5 read clears two flags");

        // R6: pending dsr flag, cts change registered with the read
        dsr_in = 1'b1;
        tick(3);
        expect_v(K_MSR, 8'h22, "R3 dsr rising flag");
        cts_in = 1'b1;
        tick(2);
        msr_rd = 1'b1;
        expect_v(K_MSR, 8'h22, "R6 value during read");
        tick(1);
        msr_rd = 1'b0;
        expect_v(K_MSR, 8'h31, "R6 new flag survives read");
        expect_v(K_IRQ, 8'h01, "R6 irq stays high");
        tick(1);
        read_msr(8'h31, 8'h30, "R5 clear after coincident read");
        dcd_in = 1'b1;
        tick(3);
        read_msr(8'hB8, 8'hB0, "R3 dcd rising flag");

        // R8: control write, upper bits dropped, outputs follow
        write_mcr(8'hE3);
        expect_v(K_MCR, 8'h03, "R8 readback masks upper bits");
        expect_v(K_PINS, 8'h03, "R8 rts and dtr follow");
        tick(1);
        write_mcr(8'h02);
        expect_v(K_PINS, 8'h02, "R8 rts only");
        tick(1);

        // R9/R10: loopback
        write_mcr(8'hFF);
        expect_v(K_MCR, 8'h1F, "R8 loop readback");
        expect_v(K_PINS, 8'h00, "R10 outputs parked in loop");
        tick(1);
        expect_v(K_MSR, 8'hF0, "R9 loop lines from control bits");
        expect_v(K_IRQ, 8'h00, "R9 ring rise in loop no flag");
        cts_in = 1'b0; dsr_in = 1'b0; dcd_in = 1'b0; ri_in = 1'b1;
        tick(5);
        expect_v(K_MSR, 8'hF0, "R9 pins ignored in loop");
        cts_in = 1'b0; dsr_in = 1'b1; dcd_in = 1'b1; ri_in = 1'b0;
        tick(3);
        write_mcr(8'h10);
        tick(1);
        expect_v(K_MSR, 8'h0F, "R9 all lines drop in loop");
        read_msr(8'h0F, 8'h00, "R5 clear in loop");
        write_mcr(8'h12);
        expect_v(K_PINS, 8'h00, "R10 rts held low in loop");
        tick(1);
        expect_v(K_MSR, 8'h11, "R9 rts drives cts");
        read_msr(8'h11, 8'h10, "R5 clear cts flag in loop");
        write_mcr(8'h08);
        tick(1);
        expect_v(K_MSR, 8'hAB, "R9 leaving loop returns to pins");
        read_msr(8'hAB, 8'hA0, "R5 clear after loop exit");

        tick(2);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        #2;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule